// File: doc/BRIEF.md
# Protected Page-Write Sequencer

This block is the write-side control of a byte-wide, paged nonvolatile memory model driven through an SRAM-style strobe interface. The interface has active-low chip enable, output enable and write enable, a 17-bit address and 8-bit data. All strobes are sampled on a system clock. Writes are refused until a fixed three-write unlock has been seen.

After the unlock, the block collects between one and a full page of bytes into a page buffer. Each buffered byte carries a valid flag. The load window closes when no new byte arrives within a byte-load timeout. A timed program phase then copies only the flagged bytes into a small backing array. When the program phase ends, the block locks itself again.

A host finds the end of a write by reading while `busy` is high. A read during that time returns status in place of array data: bit 7 is the complement of bit 7 of the last byte written, and bit 6 flips on every read.

The interface is strobe-driven, so it has no valid/ready handshake and no back-pressure. A strobe that arrives while the block cannot use it is dropped, as the requirements below describe. The backing array holds `ARRAY_PAGES` pages. Page numbers wrap modulo that count.

Top module: `pwr_page_writer`

## Requirements
- R1: Loading is enabled only by three consecutive accepted writes, compared on address bits 14..0: data 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. An accepted write that does not match the next expected step counts as an unprotected write (R6).
- R2: The three unlock writes never change the array contents.
- R3: Once unlocked, bytes may be written to any offset (address bits 6..0) in any order. A second write to the same offset in one load period replaces the first value.
- R4: The load window closes, and programming starts (`busy` rises), when LOAD_WIN clock cycles pass with no accepted byte. A window that closes with no bytes loaded still starts programming.
- R5: Programming writes only the offsets loaded in that load period. Every other byte of the array keeps its value.
- R6: An accepted write while locked that is not the next unlock step writes no data. It still drives `busy` high for the full program time.
- R7: `busy` stays high for exactly PROG_CYC clock cycles. Afterwards the block is locked again, so a plain write stores nothing.
- R8: During a load, a write whose page (address bits 16..7) differs from the first loaded byte's page is ignored. It also sets `page_err`, which stays high until reset.
- R9: A write strobe (chip enable and write enable both low) is inhibited if output enable is low at any point during the strobe. All writes are also ignored for POR_CYC cycles after reset.
- R10: A read while `busy` is high returns the complement of bit 7 of the last written byte on `dq_out[7]`. `dq_out[6]` inverts between successive reads.
- R11: A read (chip enable and output enable low, write enable high) drives `dq_oe` and returns the array byte. After reset every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data or write status |
| dq_oe | output | 1 | High while a read is driving `dq_out` |
| busy | output | 1 | Program phase in progress |
| page_err | output | 1 | Sticky flag: cross-page write during a load |

## Verification
Most faults in the internal state surface through read-back and through the `busy` pulse, not at once.

- An unlock step counter that is off by one shows up within one write: `busy` rises after a correct command write, or a correct sequence leaves the array unchanged.
- A flag or buffer-slot fault is visible only after the program phase ends, about PROG_CYC cycles later. It appears as a wrong byte, or as a changed byte at an offset that was never loaded, when the whole page is read back.
- Timer faults appear directly as a `busy` pulse of the wrong length, or as a load window that closes too early or too late.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2
  } seq_state_e;

  localparam int KEY_AW = 15;
  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_1 = 8'hAA;
  localparam logic [7:0] KEY_DATA_2 = 8'h55;
  localparam logic [7:0] KEY_DATA_3 = 8'hA0;

endpackage

// File: rtl/pwr_strobe_sync.sv
module pwr_strobe_sync #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data,
  output logic              rd_act,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              s_ce_n, s_oe_n, s_we_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              strobe, strobe_q, armed, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  // The strobe begins when the later of CE/WE falls and ends when the earlier one rises.
  assign strobe   = ~s_ce_n & ~s_we_n;
  assign rd_act   = ~s_ce_n & ~s_oe_n & s_we_n;
  assign rd_start = rd_act & ~rd_q;
  assign rd_addr  = s_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed    <= 1'b0;
      rd_q     <= 1'b0;
      ev_valid <= 1'b0;
      ev_addr  <= '0;
      ev_data  <= '0;
    end else begin
      strobe_q <= strobe;
      rd_q     <= rd_act;
      ev_valid <= ~strobe & strobe_q & armed;
      if (strobe && !strobe_q) begin
        armed   <= s_oe_n;
        ev_addr <= s_addr;
        ev_data <= s_din;
      end else if (strobe) begin
        if (!s_oe_n) armed <= 1'b0;
        ev_data <= s_din;
      end
    end
  end

  p_ev_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int OFFS_W   = 7,
  parameter int LOAD_WIN = 64,
  parameter int PROG_CYC = 200,
  parameter int POR_CYC  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic [ADDR_W-1:0]        ev_addr,
  input  logic [DATA_W-1:0]        ev_data,
  output logic                     buf_wr,
  output logic                     buf_clr,
  output logic                     scan_en,
  output logic [OFFS_W-1:0]        scan_idx,
  output logic                     busy,
  output logic                     page_err,
  output logic [ADDR_W-OFFS_W-1:0] prog_page,
  output logic [DATA_W-1:0]        last_data
);

  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int LW         = $clog2(LOAD_WIN + 1);
  localparam int PW         = $clog2(PROG_CYC + 1);
  localparam int RW         = $clog2(POR_CYC + 1);

  seq_state_e        state;
  logic [1:0]        step;
  logic [LW-1:0]     load_cnt;
  logic [PW-1:0]     prog_cnt;
  logic [RW-1:0]     por_cnt;
  logic              por_done;
  logic              page_set;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] ev_page;
  logic              page_hit;
  logic              key_ok;
  logic              ev_live;

  assign ev_page  = ev_addr[ADDR_W-1:OFFS_W];
  assign por_done = (por_cnt == RW'(POR_CYC));
  assign ev_live  = ev_valid & por_done;
  assign page_hit = !page_set || (ev_page == page_q);
  assign buf_wr   = ev_live && (state == ST_LOAD) && page_hit;
  assign busy     = (state == ST_PROG);
  assign scan_en  = busy && (prog_cnt < PW'(PAGE_BYTES));
  assign scan_idx = prog_cnt[OFFS_W-1:0];
  assign buf_clr  = busy && (prog_cnt == PW'(PROG_CYC - 1));
  assign prog_page = page_q;

  always_comb begin
    unique case (step)
      2'd0:    key_ok = (ev_addr[KEY_AW-1:0] == KEY_ADDR_A) && (ev_data == KEY_DATA_1);
      2'd1:    key_ok = (ev_addr[KEY_AW-1:0] == KEY_ADDR_B) && (ev_data == KEY_DATA_2);
      default: key_ok = (ev_addr[KEY_AW-1:0] == KEY_ADDR_A) && (ev_data == KEY_DATA_3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_cnt <= '0;
    else if (!por_done) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOCKED;
      step      <= 2'd0;
      load_cnt  <= '0;
      prog_cnt  <= '0;
      page_set  <= 1'b0;
      page_q    <= '0;
      page_err  <= 1'b0;
      last_data <= '0;
    end else begin
      unique case (state)
        ST_LOCKED: begin
          if (ev_live) begin
            last_data <= ev_data;
            if (!key_ok) begin
              state    <= ST_PROG;
              prog_cnt <= '0;
              step     <= 2'd0;
            end else if (step == 2'd2) begin
              state    <= ST_LOAD;
              step     <= 2'd0;
              load_cnt <= LW'(LOAD_WIN - 1);
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        ST_LOAD: begin
          if (buf_wr) begin
            load_cnt  <= LW'(LOAD_WIN - 1);
            page_set  <= 1'b1;
            page_q    <= ev_page;
            last_data <= ev_data;
          end else begin
            if (ev_live) page_err <= 1'b1;
            if (load_cnt == '0) begin
              state    <= ST_PROG;
              prog_cnt <= '0;
            end else begin
              load_cnt <= load_cnt - 1'b1;
            end
          end
        end
        default: begin
          if (prog_cnt == PW'(PROG_CYC - 1)) begin
            state    <= ST_LOCKED;
            step     <= 2'd0;
            page_set <= 1'b0;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  p_por_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !busy);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  p_mismatch_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_live && state == ST_LOAD && page_set && ev_page != page_q) |=> page_err);

  p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (step == 2'd0 && !page_set && state == ST_LOCKED));

  p_win_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && load_cnt == '0 && !buf_wr) |=> busy);

endmodule

// File: rtl/pwr_page_buf.sv
module pwr_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFFS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFFS_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFFS_W-1:0] rd_idx,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAGE_BYTES = 1 << OFFS_W;

  logic [PAGE_BYTES-1:0] flags;
  logic [DATA_W-1:0]     slot [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        slot[i]  <= '0;
      end else if (clr) begin
        flags[i] <= 1'b0;
      end else if (wr && wr_off == OFFS_W'(i)) begin
        flags[i] <= 1'b1;
        slot[i]  <= wr_data;
      end
    end
  end

  assign rd_flag = flags[rd_idx];
  assign rd_data = slot[rd_idx];

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($countones(flags) == 0));

endmodule

// File: rtl/pwr_array.sv
module pwr_array #(
  parameter int DATA_W   = 8,
  parameter int INDEX_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [INDEX_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [INDEX_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);

  localparam int DEPTH = 1 << INDEX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pwr_page_writer.sv
module pwr_page_writer #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 7,
  parameter int ARRAY_PAGES = 4,
  parameter int LOAD_WIN    = 64,
  parameter int PROG_CYC    = 200,
  parameter int POR_CYC     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              page_err
);

  localparam int PAGE_W   = ADDR_W - OFFS_W;
  localparam int PG_SEL_W = $clog2(ARRAY_PAGES);
  localparam int INDEX_W  = PG_SEL_W + OFFS_W;

  logic              ev_valid, rd_act, rd_start;
  logic [ADDR_W-1:0] ev_addr, rd_addr;
  logic [DATA_W-1:0] ev_data, last_data, buf_data, arr_rdata;
  logic              buf_wr, buf_clr, scan_en, buf_flag, commit_we, tog;
  logic [OFFS_W-1:0] scan_idx;
  logic [PAGE_W-1:0] prog_page;
  logic [INDEX_W-1:0] commit_idx, read_idx;

  pwr_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(dq_in), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_data(ev_data), .rd_act(rd_act), .rd_start(rd_start), .rd_addr(rd_addr)
  );

  pwr_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_data(ev_data), .buf_wr(buf_wr), .buf_clr(buf_clr), .scan_en(scan_en),
    .scan_idx(scan_idx), .busy(busy), .page_err(page_err),
    .prog_page(prog_page), .last_data(last_data)
  );

  pwr_page_buf #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(buf_wr), .wr_off(ev_addr[OFFS_W-1:0]),
    .wr_data(ev_data), .clr(buf_clr), .rd_idx(scan_idx),
    .rd_flag(buf_flag), .rd_data(buf_data)
  );

  assign commit_we  = scan_en & buf_flag;
  assign commit_idx = {prog_page[PG_SEL_W-1:0], scan_idx};
  assign read_idx   = {rd_addr[OFFS_W+PG_SEL_W-1:OFFS_W], rd_addr[OFFS_W-1:0]};

  pwr_array #(.DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .waddr(commit_idx),
    .wdata(buf_data), .raddr(read_idx), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog    <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      if (rd_start) tog <= ~tog;
      dq_oe <= rd_act;
      if (rd_act) begin
        if (busy) dq_out <= {~last_data[DATA_W-1], tog, last_data[DATA_W-3:0]};
        else      dq_out <= arr_rdata;
      end
    end
  end

  p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> busy);

  p_read_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(rd_act));

endmodule

// File: tb/pwr_page_writer_test.sv
module pwr_page_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 40;
  localparam int PC = 160;
  localparam int PR = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dq_in = '0, dq_out;
  logic dq_oe, busy, page_err;

  int errors = 0, checks = 0, busy_cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_page_writer #(.ARRAY_PAGES(4), .LOAD_WIN(LW), .PROG_CYC(PC), .POR_CYC(PR)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .busy(busy), .page_err(page_err)
  );

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic oe_lvl = 1'b1);
    @(negedge clk);
    addr = a; dq_in = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'hA0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy == 1'b0 && n < LW + 20) begin @(negedge clk); n++; end
    n = 0;
    while (busy == 1'b1 && n < PC + 20) begin @(negedge clk); n++; end
  endtask

  function automatic logic [16:0] pa(input int page, input int off);
    return 17'((page << 7) | off);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    check("R11 reset dq_oe", int'(dq_oe), 0);
    check("R7 reset busy", int'(busy), 0);
    check("R8 reset page_err", int'(page_err), 0);
    rst_n = 1'b1;

    // R9: write during power-on delay is ignored
    wr(pa(1, 3), 8'h12);
    repeat (10) @(negedge clk);
    check("R9 write during power-on ignored", int'(busy), 0);
    repeat (PR) @(negedge clk);

    // R11: erased content of page 0
    for (int i = 0; i < 128; i++) begin
      rd(pa(0, i), v);
      check("R11 erased byte", int'(v), 8'hFF);
    end

    // R3/R5/R7: full page 1, descending order, offset 10 overwritten
    unlock();
    wr(pa(1, 10), 8'h00);
    for (int i = 127; i >= 0; i--) wr(pa(1, i), 8'((i * 7 + 3) & 8'hFF));
    busy_cycles = 0;
    wait_idle();
    check("R7 busy length full page", busy_cycles, PC);
    for (int i = 0; i < 128; i++) begin
      rd(pa(1, i), v);
      check("R3 R5 full page readback", int'(v), (i * 7 + 3) & 8'hFF);
    end

    // R4/R5/R2: sparse page 2, window timing
    unlock();
    for (int i = 0; i < 128; i += 3) wr(pa(2, i), 8'(i ^ 8'h5A));
    repeat (28) @(negedge clk);
    check("R4 window still open", int'(busy), 0);
    repeat (20) @(negedge clk);
    check("R4 window expired", int'(busy), 1);
    wait_idle();
    for (int i = 0; i < 128; i++) begin
      rd(pa(2, i), v);
      check("R5 R2 sparse readback", int'(v), (i % 3 == 0) ? (i ^ 8'h5A) : 8'hFF);
    end

    // R6/R10: unprotected write
    busy_cycles = 0;
    wr(pa(3, 16), 8'h33);
    check("R6 unprotected write starts busy", int'(busy), 1);
    rd(pa(3, 16), v);
    rd(pa(3, 16), v2);
    check("R10 polling bit7", int'(v[7]), 1);
    check("R10 polling bit7 second", int'(v2[7]), 1);
    check("R10 toggle bit differs", int'(v[6] ^ v2[6]), 1);
    wait_idle();
    check("R6 R7 busy length", busy_cycles, PC);
    rd(pa(3, 16), v);
    check("R6 no data written", int'(v), 8'hFF);

    // R7: relocked after program, plain write stores nothing
    wr(pa(1, 0), 8'h99);
    wait_idle();
    rd(pa(1, 0), v);
    check("R7 relocked plain write", int'(v), 3);

    // R1: wrong second step
    wr(17'h05555, 8'hAA);
    check("R1 first step accepted quietly", int'(busy), 0);
    wr(17'h02AAB, 8'h55);
    check("R1 bad second step -> busy", int'(busy), 1);
    wait_idle();
    rd(pa(1, 8'h2B), v);
    check("R1 bad step no data", int'(v), (8'h2B * 7 + 3) & 8'hFF);

    // R9: OE low inhibits write
    unlock();
    wr(pa(0, 7), 8'h77, 1'b0);
    wait_idle();
    rd(pa(0, 7), v);
    check("R9 OE-low write inhibited", int'(v), 8'hFF);

    // R8: cross-page write ignored, sticky flag
    unlock();
    wr(pa(0, 5), 8'h11);
    wr(pa(3, 6), 8'h22);
    @(negedge clk);
    check("R8 page_err set", int'(page_err), 1);
    wait_idle();
    rd(pa(0, 5), v);
    check("R8 first page byte written", int'(v), 8'h11);
    rd(pa(3, 6), v);
    check("R8 other page byte ignored", int'(v), 8'hFF);
    check("R8 page_err sticky", int'(page_err), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule